// File: doc/BRIEF.md
# Parallel display pixel packer

This block sits between a pixel stream and the parallel data bus of a command-driven display panel. It takes whole pixels through a valid/ready input and splits each one into bus words. The number of words depends on the pixel depth (12, 16, 18 or 24 bits) and on the number of active bus lines (8, 9, 12 or 16). When the depth is one and a half times the bus width, two pixels share three words. A frame transfer starts with a pixel count. The block takes exactly that many pixels, sends their words, and then pulses a done flag and drops its busy state by itself.

When no frame is active, the same bus can also carry single register traffic: a command word, a parameter word, or one read cycle whose sampled value is held for software. The strobe waveform is handled elsewhere. Each bus word is offered with a valid line and counts as finished in the clock cycle where the bus side raises its done line.

Top module: `disp_pixel_packer`

## Requirements
- R1: The depth code (0..3 = 12, 16, 18, 24 bits) and the line code (0..3 = 8, 9, 12, 16 lines) select the split. Depth/lines of 1, 2 or 3 gives that many words per pixel. Twice depth over lines equal to 3 gives the pair format. Every other pair raises `cfgError`, and a frame start is then ignored.
- R2: In the one-word format, each pixel uses a single bus cycle that carries its low `lines` bits. Pixel bits above the depth are ignored, and bus bits above the active lines are driven zero.
- R3: In the two-word format, the more significant `lines`-bit half of a pixel goes out first, followed by the less significant half. For example, 16 bits on 8 lines gives the high byte and then the low byte.
- R4: In the three-word format, the pixel goes out from its most significant chunk down. For 24 bits on 8 lines this is bits 23:16, then 15:8, then 7:0.
- R5: In the pair format, with h = lines/2, the three words of a pixel pair are as follows. Word one is the top `lines` bits of the first pixel. Word two is the first pixel's low h bits in its upper half and the second pixel's top h bits in its lower half. Word three is the second pixel's low `lines` bits.
- R6: If a frame in the pair format ends on an unpaired pixel, only two words are sent for it. The lower half of the second word is zero.
- R7: `busy` is high from the cycle after an accepted start until the final word completes. `pixReady` is only high while busy and is never high after `pixelCount` pixels have been taken. `frameDone` is high for the one cycle after the final word completes, and `busy` is low in that same cycle.
- R8: A start with a pixel count of zero raises `frameDone` in the next cycle and produces no bus cycle.
- R9: A command write produces one bus cycle with `busIsData` = 0, `busRead` = 0 and `busData` equal to `wrData`.
- R10: A parameter write produces one bus cycle with `busIsData` = 1 and `busData` = `wrData`. Every pixel word is also sent with `busIsData` = 1 and `busRead` = 0.
- R11: A read request produces one bus cycle with `busRead` = 1 and `busIsData` = 1. The `busIn` value present in the cycle where that cycle completes then appears on `readData`.
- R12: While `busValid` is high and `busDone` is low, `busValid`, `busData`, `busIsData` and `busRead` hold their values into the next cycle.
- R13: Start and register requests are taken only when the block is idle, with a frame start taking priority, then command, then parameter, then read. Requests that arrive during a frame or a register cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgDataType | input | 2 | Pixel depth code |
| cfgLines | input | 2 | Active bus line code |
| cfgError | output | 1 | Depth/line pair is not supported |
| startFrame | input | 1 | Start a frame transfer |
| pixelCount | input | CNT_W | Pixels in the frame, sampled at start |
| busy | output | 1 | Frame transfer in progress |
| frameDone | output | 1 | One-cycle end-of-frame pulse |
| pixValid | input | 1 | Pixel input valid |
| pixData | input | 24 | Pixel, right aligned |
| pixReady | output | 1 | Pixel input ready |
| cmdWrite | input | 1 | Request a command bus cycle |
| paramWrite | input | 1 | Request a parameter bus cycle |
| wrData | input | 16 | Word for command or parameter cycles |
| readStart | input | 1 | Request a read bus cycle |
| readData | output | 16 | Value sampled by the last read cycle |
| busValid | output | 1 | Bus cycle requested |
| busDone | input | 1 | Bus cycle completes this clock |
| busIsData | output | 1 | Command/data select, 1 = data |
| busRead | output | 1 | Current cycle is a read |
| busData | output | 16 | Bus word to drive |
| busIn | input | 16 | Bus value seen on read cycles |

## Verification
Wrong control state shows up directly on the bus. A beat counter or pair state that is off places a wrong chunk, or an extra or missing word, on `busData` in the very cycle that word completes. Each completed word is checked against an independently computed list at that moment. A pixel counter that is off moves `frameDone` by at least one word time, or lets `pixReady` rise once more than it should. The per-cycle comparison of `frameDone` and the check for unexpected bus cycles expose either of these within a cycle.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  localparam int BUS_W = 16;
  localparam int PIX_W = 24;

  typedef enum logic [1:0] {FMT_ONE = 2'd0, FMT_TWO = 2'd1, FMT_THREE = 2'd2, FMT_PAIR = 2'd3} cycFmt_t;
  typedef enum logic [2:0] {S_IDLE, S_WAIT_A, S_WAIT_B, S_BEAT, S_REG} ctrlState_t;

  typedef struct packed {
    logic       loadCfg;
    logic       loadA;
    logic       loadB;
    logic       clearB;
    logic       loadReg;
    logic       capRead;
    logic       regSel;
    logic [1:0] beat;
  } dpStrobe_t;

  function automatic int bppOf(logic [1:0] code);
    case (code)
      2'd0: return 12;
      2'd1: return 16;
      2'd2: return 18;
      default: return 24;
    endcase
  endfunction

  function automatic int linesOf(logic [1:0] code);
    case (code)
      2'd0: return 8;
      2'd1: return 9;
      2'd2: return 12;
      default: return 16;
    endcase
  endfunction

  // {supported, format}
  function automatic logic [2:0] pickFmt(logic [1:0] dt, logic [1:0] pm);
    int b;
    int l;
    b = bppOf(dt);
    l = linesOf(pm);
    if ((b % l) == 0 && (b / l) >= 1 && (b / l) <= 3) return {1'b1, 2'(b / l - 1)};
    else if (((2 * b) % l) == 0 && ((2 * b) / l) == 3) return {1'b1, 2'd3};
    else return 3'b000;
  endfunction
endpackage

// File: rtl/dpp_ctrl.sv
module dpp_ctrl
  import dpp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgOk,
  input  logic [1:0]       cfgFmt,
  input  logic             startFrame,
  input  logic [CNT_W-1:0] pixelCount,
  input  logic             pixValid,
  input  logic             cmdWrite,
  input  logic             paramWrite,
  input  logic             readStart,
  input  logic             busDone,
  output logic             pixReady,
  output logic             busy,
  output logic             frameDone,
  output logic             busValid,
  output logic             busIsData,
  output logic             busRead,
  output cycFmt_t          fmtQ,
  output dpStrobe_t        strobe
);
  ctrlState_t       state;
  logic [1:0]       beat;
  logic [CNT_W-1:0] remaining;
  logic             flushing;
  logic             regIsData;
  logic             regRead;
  logic             startOk;
  logic             regGo;
  logic             fire;

  assign startOk   = (state == S_IDLE) && startFrame && cfgOk;
  assign regGo     = (state == S_IDLE) && !startOk && (cmdWrite || paramWrite || readStart);
  assign pixReady  = (state == S_WAIT_A) || (state == S_WAIT_B);
  assign busy      = pixReady || (state == S_BEAT);
  assign busValid  = (state == S_BEAT) || (state == S_REG);
  assign busIsData = (state == S_REG) ? regIsData : 1'b1;
  assign busRead   = (state == S_REG) && regRead;
  assign fire      = busValid && busDone;

  always_comb begin
    strobe         = '0;
    strobe.loadCfg = startOk;
    strobe.loadA   = (state == S_WAIT_A) && pixValid;
    strobe.loadB   = (state == S_WAIT_B) && pixValid;
    strobe.clearB  = (state == S_BEAT) && fire && (fmtQ == FMT_PAIR) && (beat == 2'd0) && (remaining == '0);
    strobe.loadReg = regGo;
    strobe.capRead = (state == S_REG) && fire && regRead;
    strobe.regSel  = (state == S_REG);
    strobe.beat    = beat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      beat      <= '0;
      remaining <= '0;
      flushing  <= 1'b0;
      regIsData <= 1'b0;
      regRead   <= 1'b0;
      fmtQ      <= FMT_ONE;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (state)
        S_IDLE: begin
          if (startOk) begin
            remaining <= pixelCount;
            fmtQ      <= cycFmt_t'(cfgFmt);
            flushing  <= 1'b0;
            if (pixelCount == '0) frameDone <= 1'b1;
            else state <= S_WAIT_A;
          end else if (regGo) begin
            regIsData <= !cmdWrite;
            regRead   <= !cmdWrite && !paramWrite;
            state     <= S_REG;
          end
        end
        S_WAIT_A: if (pixValid) begin
          remaining <= remaining - 1'b1;
          beat      <= 2'd0;
          state     <= S_BEAT;
        end
        S_WAIT_B: if (pixValid) begin
          remaining <= remaining - 1'b1;
          beat      <= 2'd1;
          state     <= S_BEAT;
        end
        S_BEAT: if (busDone) begin
          if (fmtQ == FMT_PAIR) begin
            if (beat == 2'd0) begin
              if (remaining != '0) state <= S_WAIT_B;
              else begin
                flushing <= 1'b1;
                beat     <= 2'd1;
              end
            end else if (beat == 2'd1 && !flushing) begin
              beat <= 2'd2;
            end else if (beat == 2'd1 || remaining == '0) begin
              state     <= S_IDLE;
              frameDone <= 1'b1;
            end else begin
              state <= S_WAIT_A;
            end
          end else if (beat == 2'(fmtQ)) begin
            if (remaining == '0) begin
              state     <= S_IDLE;
              frameDone <= 1'b1;
            end else begin
              state <= S_WAIT_A;
            end
          end else begin
            beat <= beat + 2'd1;
          end
        end
        S_REG: if (busDone) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_no_pix_past_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    pixReady |-> (remaining != '0));
  p_done_drops_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !busy);
  p_bad_cfg_start_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_IDLE) && startFrame && !cfgOk) |=> !busy);
  p_cmd_dropped_in_frame_r13: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrite) |=> !(busValid && !busIsData));
endmodule

// File: rtl/dpp_datapath.sv
module dpp_datapath
  import dpp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  cycFmt_t          fmtQ,
  input  logic [1:0]       cfgDataType,
  input  logic [1:0]       cfgLines,
  input  logic [PIX_W-1:0] pixData,
  input  logic [BUS_W-1:0] wrData,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busData,
  output logic [BUS_W-1:0] readData
);
  logic [1:0]       dtQ;
  logic [1:0]       pmQ;
  logic [PIX_W-1:0] pixA;
  logic [PIX_W-1:0] pixB;
  logic [BUS_W-1:0] regWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dtQ      <= '0;
      pmQ      <= '0;
      pixA     <= '0;
      pixB     <= '0;
      regWord  <= '0;
      readData <= '0;
    end else begin
      if (strobe.loadCfg) begin
        dtQ <= cfgDataType;
        pmQ <= cfgLines;
      end
      if (strobe.loadA) pixA <= pixData;
      if (strobe.loadB) pixB <= pixData;
      else if (strobe.clearB) pixB <= '0;
      if (strobe.loadReg) regWord <= wrData;
      if (strobe.capRead) readData <= busIn;
    end
  end

  always_comb begin
    int b;
    int l;
    int h;
    int sh;
    logic [31:0] a;
    logic [31:0] c;
    logic [31:0] mask;
    logic [31:0] hmask;
    logic [31:0] w;
    b     = bppOf(dtQ);
    l     = linesOf(pmQ);
    h     = l / 2;
    a     = {{(32-PIX_W){1'b0}}, pixA};
    c     = {{(32-PIX_W){1'b0}}, pixB};
    mask  = (32'd1 << l) - 32'd1;
    hmask = (32'd1 << h) - 32'd1;
    sh    = b - (int'(strobe.beat) + 1) * l;
    if (strobe.regSel) begin
      w = {{(32-BUS_W){1'b0}}, regWord};
    end else if (fmtQ == FMT_PAIR) begin
      case (strobe.beat)
        2'd0:    w = (a >> (b - l)) & mask;
        2'd1:    w = ((a & hmask) << h) | ((c >> (b - h)) & hmask);
        default: w = c & mask;
      endcase
    end else begin
      w = (sh >= 0) ? ((a >> sh) & mask) : 32'd0;
    end
    busData = w[BUS_W-1:0];
  end
endmodule

// File: rtl/disp_pixel_packer.sv
module disp_pixel_packer
  import dpp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgDataType,
  input  logic [1:0]       cfgLines,
  output logic             cfgError,
  input  logic             startFrame,
  input  logic [CNT_W-1:0] pixelCount,
  output logic             busy,
  output logic             frameDone,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  output logic             pixReady,
  input  logic             cmdWrite,
  input  logic             paramWrite,
  input  logic [BUS_W-1:0] wrData,
  input  logic             readStart,
  output logic [BUS_W-1:0] readData,
  output logic             busValid,
  input  logic             busDone,
  output logic             busIsData,
  output logic             busRead,
  output logic [BUS_W-1:0] busData,
  input  logic [BUS_W-1:0] busIn
);
  logic [2:0] fmtPick;
  dpStrobe_t  strobe;
  cycFmt_t    fmtQ;

  assign fmtPick  = pickFmt(cfgDataType, cfgLines);
  assign cfgError = !fmtPick[2];

  dpp_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgOk(fmtPick[2]), .cfgFmt(fmtPick[1:0]),
    .startFrame(startFrame), .pixelCount(pixelCount), .pixValid(pixValid),
    .cmdWrite(cmdWrite), .paramWrite(paramWrite), .readStart(readStart),
    .busDone(busDone), .pixReady(pixReady), .busy(busy), .frameDone(frameDone),
    .busValid(busValid), .busIsData(busIsData), .busRead(busRead),
    .fmtQ(fmtQ), .strobe(strobe)
  );

  dpp_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fmtQ(fmtQ),
    .cfgDataType(cfgDataType), .cfgLines(cfgLines), .pixData(pixData),
    .wrData(wrData), .busIn(busIn), .busData(busData), .readData(readData)
  );

  p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busDone) |=> (busValid && $stable(busData) && $stable(busIsData) && $stable(busRead)));
  p_pixel_words_are_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busy) |-> (busIsData && !busRead));
  p_read_is_data_level_r11: assert property (@(posedge clk) disable iff (!rstN)
    busRead |-> (busValid && busIsData));
endmodule

// File: tb/test_disp_pixel_packer.sv
module test_disp_pixel_packer;
  logic        clk = 0;
  logic        rstN = 0;
  logic [1:0]  cfgDataType = 0;
  logic [1:0]  cfgLines = 0;
  logic        cfgError;
  logic        startFrame = 0;
  logic [15:0] pixelCount = 0;
  logic        busy, frameDone, pixReady, busValid, busIsData, busRead;
  logic        pixValid = 0;
  logic [23:0] pixData = 0;
  logic        cmdWrite = 0, paramWrite = 0, readStart = 0;
  logic [15:0] wrData = 0;
  logic [15:0] readData, busData;
  logic        busDone = 0;
  logic [15:0] busIn = 0;

  int checks = 0;
  int errors = 0;
  bit doneNext = 0;
  bit zeroPending = 0;
  int expW[$];
  bit expD[$];
  bit expR[$];
  bit expL[$];
  int expRv[$];
  string expT[$];

  always #4 clk = ~clk;

  disp_pixel_packer i_disp_pixel_packer (
    .clk(clk), .rstN(rstN), .cfgDataType(cfgDataType), .cfgLines(cfgLines),
    .cfgError(cfgError), .startFrame(startFrame), .pixelCount(pixelCount),
    .busy(busy), .frameDone(frameDone), .pixValid(pixValid), .pixData(pixData),
    .pixReady(pixReady), .cmdWrite(cmdWrite), .paramWrite(paramWrite),
    .wrData(wrData), .readStart(readStart), .readData(readData),
    .busValid(busValid), .busDone(busDone), .busIsData(busIsData),
    .busRead(busRead), .busData(busData), .busIn(busIn)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int bppN(int c);
    return c == 0 ? 12 : c == 1 ? 16 : c == 2 ? 18 : 24;
  endfunction
  function automatic int linesN(int c);
    return c == 0 ? 8 : c == 1 ? 9 : c == 2 ? 12 : 16;
  endfunction

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // bus responder and per-clock comparison against the reference lists
  always @(negedge clk) begin
    if (rstN) begin
      bit expDone;
      expDone = doneNext || zeroPending;
      zeroPending = 0;
      doneNext = 0;
      check(frameDone == expDone, "R7/R8 frameDone timing", frameDone, expDone);
      busDone = 0;
      if (busValid) begin
        if (expW.size() == 0) begin
          check(0, "R13 unexpected bus cycle", busData, 0);
        end else if ($urandom_range(0, 3) != 0) begin
          bit ok;
          ok = (busIsData == expD[0]) && (busRead == expR[0]) &&
               (expW[0] < 0 || busData == expW[0][15:0]);
          check(ok, expT[0], {busIsData, busRead, busData}, {expD[0], expR[0], expW[0][15:0]});
          busDone = 1;
          if (expR[0]) busIn = expRv[0][15:0];
          doneNext = expL[0];
          void'(expW.pop_front()); void'(expD.pop_front()); void'(expR.pop_front());
          void'(expL.pop_front()); void'(expRv.pop_front()); void'(expT.pop_front());
        end
      end
    end
  end

  task automatic pushBeat(int w, bit d, bit r, bit last, int rv, string tag);
    expW.push_back(w); expD.push_back(d); expR.push_back(r);
    expL.push_back(last); expRv.push_back(rv); expT.push_back(tag);
  endtask

  task automatic drain();
    while (expW.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic runFrame(int dt, int pm, int n, bit withCmd, string tag);
    int B, L;
    int pix[$];
    longint pm64, lm64;
    B = bppN(dt);
    L = linesN(pm);
    pm64 = (64'd1 << B) - 1;
    lm64 = (64'd1 << L) - 1;
    for (int i = 0; i < n; i++) pix.push_back(int'($urandom & 32'hFFFFFF));
    if (B % L == 0) begin
      for (int i = 0; i < n; i++) begin
        longint s;
        s = pix[i] & pm64;
        for (int j = 0; j < B / L; j++)
          pushBeat(int'((s >> (B - (j + 1) * L)) & lm64), 1, 0, (i == n - 1) && (j == B / L - 1), 0, tag);
      end
    end else begin
      for (int i = 0; i < n; i += 2) begin
        longint s;
        int nb;
        bit odd;
        odd = (i + 1 >= n);
        s = ((pix[i] & pm64) << B) | (odd ? 64'd0 : (pix[i + 1] & pm64));
        nb = odd ? 2 : 3;
        for (int j = 0; j < nb; j++)
          pushBeat(int'((s >> (2 * B - (j + 1) * L)) & lm64), 1, 0, (i + 2 >= n) && (j == nb - 1), 0,
                   (odd && j == 1) ? "R6 unpaired flush word" : tag);
      end
    end
    @(negedge clk);
    cfgDataType = 2'(dt);
    cfgLines = 2'(pm);
    pixelCount = 16'(n);
    startFrame = 1;
    #1 if (n == 0) zeroPending = 1;
    @(negedge clk);
    startFrame = 0;
    check(busy == (n != 0), "R7 busy after start", busy, n != 0);
    if (withCmd) begin
      cmdWrite = 1;
      wrData = 16'hDEAD;
      @(negedge clk);
      cmdWrite = 0;
    end
    for (int i = 0; i < n; i++) begin
      bit rdy;
      if ($urandom_range(0, 3) == 0) begin
        pixValid = 0;
        @(negedge clk);
      end
      pixValid = 1;
      pixData = pix[i][23:0];
      forever begin
        rdy = pixReady;
        @(negedge clk);
        if (rdy) break;
      end
    end
    pixValid = 0;
    drain();
    check(!busy && !pixReady, "R7 idle after frame", {busy, pixReady}, 0);
  endtask

  task automatic regOp(int kind, int val, string tag);
    pushBeat(kind == 2 ? -1 : val, kind != 0, kind == 2, 0, val, tag);
    @(negedge clk);
    wrData = val[15:0];
    cmdWrite = (kind == 0);
    paramWrite = (kind == 1);
    readStart = (kind == 2);
    @(negedge clk);
    cmdWrite = 0; paramWrite = 0; readStart = 0;
    drain();
    if (kind == 2) check(readData == val[15:0], "R11 read value returned", readData, val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finishSim();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !pixReady && !busValid && !frameDone && readData == 0,
          "reset state", {busy, pixReady, busValid, frameDone}, 0);
    rstN = 1;
    @(negedge clk);

    // R1: every code pair against the arithmetic rule
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 4; p++) begin
        int B, L;
        bit ok;
        B = bppN(d); L = linesN(p);
        ok = ((B % L) == 0 && B / L <= 3) || (((2 * B) % L) == 0 && (2 * B) / L == 3);
        cfgDataType = 2'(d); cfgLines = 2'(p);
        #1 check(cfgError == !ok, "R1 format support", cfgError, !ok);
      end
    end

    // R1: rejected pair (16 bits on 12 lines) ignores a start
    @(negedge clk);
    cfgDataType = 1; cfgLines = 2; pixelCount = 4; startFrame = 1;
    @(negedge clk);
    startFrame = 0;
    repeat (4) begin
      check(!busy && !pixReady, "R1 start ignored on bad format", {busy, pixReady}, 0);
      @(negedge clk);
    end

    runFrame(3, 3, 0, 0, "R2");                        // 24 bits on 16 lines is pair; zero count
    runFrame(1, 3, 4, 0, "R2 one-word 16/16");
    runFrame(0, 2, 3, 0, "R2 one-word 12/12");
    runFrame(1, 0, 3, 1, "R3 two-word 16/8");          // command during frame dropped (R13)
    runFrame(2, 1, 2, 0, "R3 two-word 18/9");
    runFrame(3, 2, 2, 0, "R3 two-word 24/12");
    runFrame(3, 0, 3, 0, "R4 three-word 24/8");
    runFrame(0, 0, 4, 0, "R5 pair 12/8");
    runFrame(3, 3, 3, 0, "R5 pair 24/16");
    runFrame(2, 2, 5, 1, "R5 pair 18/12");
    runFrame(0, 0, 1, 0, "R6 pair single pixel");
    runFrame(1, 0, 0, 0, "R8 zero count");

    regOp(0, 16'h002C, "R9 command write");
    regOp(1, 16'hA5C3, "R10 parameter write");
    regOp(2, 16'h5A17, "R11 read cycle");
    regOp(2, 16'h0F0E, "R11 second read");

    // R13: simultaneous requests, the command wins and the others are dropped
    pushBeat(16'h1234, 0, 0, 0, 0, "R13 command priority");
    @(negedge clk);
    wrData = 16'h1234; cmdWrite = 1; paramWrite = 1; readStart = 1;
    @(negedge clk);
    cmdWrite = 0; paramWrite = 0; readStart = 0;
    drain();
    check(!busValid, "R13 one cycle only", busValid, 0);

    finishSim();
  end
endmodule